// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block builds the memory address for one operand in a real-mode segmented memory model. Every cycle it takes the base registers (BX, BP), the index registers (SI, DI), a displacement, and selectors that say which of these parts take part. It adds them into a 16-bit effective address. It then picks one of the four 16-bit segment registers (code, data, stack, extra), shifts that segment value left by four bits and adds the effective address. The result is a 20-bit physical address.

By default, the segment comes from the base register in use. A caller can force a different segment with an override request. A string-destination request forces the extra segment. All three results are registered and are valid one clock after the inputs that produce them.

Top module: `seg_addr_gen`

## Requirements
- R1: `ea_q` is the sum of the selected base, the selected index and the selected displacement, taken modulo 2^16. Any carry out of bit 15 is discarded.
- R2: `disp_mode` picks the displacement part: 0 means none, 1 means the low 8 bits of `disp` sign-extended to 16 bits, 2 means all 16 bits of `disp`, and 3 means none.
- R3: `base_sel` picks the base part: 0 means none, 1 means `reg_bx`, 2 means `reg_bp`, 3 means none. `idx_sel` picks the index part: 0 means none, 1 means `reg_si`, 2 means `reg_di`, 3 means none. A part that is not selected has no effect on the result.
- R4: `seg_q` uses the code 0 for code, 1 for data, 2 for stack and 3 for extra. With no override and no string destination, `seg_q` is 2 (stack) when `base_sel` is 2. In every other such case it is 1 (data).
- R5: When `ovr_en` is 1 and `str_dst` is 0, `seg_q` equals `ovr_seg`, and that segment register is used for the physical address.
- R6: When `str_dst` is 1, `seg_q` is 3 (extra) whatever `ovr_en` and `ovr_seg` are.
- R7: `pa_q` equals (chosen segment value × 16 + `ea_q`) modulo 2^20. Any carry out of bit 19 is discarded.
- R8: Each output takes on the value for a set of inputs on the first rising clock edge after those inputs are applied. Before that edge the output keeps its previous value.
- R9: While `rst_n` is low, `ea_q`, `seg_q` and `pa_q` are all zero.
- R10: Without an override or a string destination, `seg_q` is never 3 (extra).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| base_sel | input | 2 | Base part select |
| idx_sel | input | 2 | Index part select |
| disp_mode | input | 2 | Displacement part select |
| disp | input | 16 | Displacement value |
| reg_bx | input | 16 | BX base register value |
| reg_bp | input | 16 | BP base register value |
| reg_si | input | 16 | SI index register value |
| reg_di | input | 16 | DI index register value |
| ovr_en | input | 1 | Segment override request |
| ovr_seg | input | 2 | Segment code used on override |
| str_dst | input | 1 | String destination, forces extra segment |
| seg_cs | input | 16 | Code segment register |
| seg_ds | input | 16 | Data segment register |
| seg_ss | input | 16 | Stack segment register |
| seg_es | input | 16 | Extra segment register |
| ea_q | output | 16 | Registered effective address |
| seg_q | output | 2 | Registered chosen segment code |
| pa_q | output | 20 | Registered physical address |

## Verification
All three outputs sit one register stage after the inputs. The effective address, the segment code and the physical address for a set of inputs therefore all appear together on the first rising edge after those inputs are applied. The bench changes its inputs on a falling edge. Before the next rising edge it checks that the outputs still hold the previous result, and it compares the new result on the following falling edge, so each sample falls half a period away from any edge. The checker computes the expected physical address from the segment registers as they were one cycle earlier, which matches the one-cycle latency of the physical address.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int EA_W      = 16,
  parameter int SEG_SHIFT = 4,
  parameter int DSHORT_W  = 8,
  localparam int PA_W     = EA_W + SEG_SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      base_sel,
  input  logic [1:0]      idx_sel,
  input  logic [1:0]      disp_mode,
  input  logic [EA_W-1:0] disp,
  input  logic [EA_W-1:0] reg_bx,
  input  logic [EA_W-1:0] reg_bp,
  input  logic [EA_W-1:0] reg_si,
  input  logic [EA_W-1:0] reg_di,
  input  logic            ovr_en,
  input  logic [1:0]      ovr_seg,
  input  logic            str_dst,
  input  logic [EA_W-1:0] seg_cs,
  input  logic [EA_W-1:0] seg_ds,
  input  logic [EA_W-1:0] seg_ss,
  input  logic [EA_W-1:0] seg_es,
  output logic [EA_W-1:0] ea_q,
  output logic [1:0]      seg_q,
  output logic [PA_W-1:0] pa_q
);
  localparam logic [1:0] SEG_CODE  = 2'd0;
  localparam logic [1:0] SEG_DATA  = 2'd1;
  localparam logic [1:0] SEG_STACK = 2'd2;
  localparam logic [1:0] SEG_EXTRA = 2'd3;

  logic [EA_W-1:0] base_v, idx_v, disp_v, ea_d, seg_v;
  logic [1:0]      seg_d;
  logic [PA_W-1:0] pa_d;

  always_comb begin
    case (base_sel)
      2'd1:    base_v = reg_bx;
      2'd2:    base_v = reg_bp;
      default: base_v = '0;
    endcase
    case (idx_sel)
      2'd1:    idx_v = reg_si;
      2'd2:    idx_v = reg_di;
      default: idx_v = '0;
    endcase
    case (disp_mode)
      2'd1:    disp_v = {{(EA_W-DSHORT_W){disp[DSHORT_W-1]}}, disp[DSHORT_W-1:0]};
      2'd2:    disp_v = disp;
      default: disp_v = '0;
    endcase
  end

  assign ea_d = base_v + idx_v + disp_v;

  always_comb begin
    if (str_dst)             seg_d = SEG_EXTRA;
    else if (ovr_en)         seg_d = ovr_seg;
    else if (base_sel == 2'd2) seg_d = SEG_STACK;
    else                     seg_d = SEG_DATA;
    case (seg_d)
      SEG_CODE:  seg_v = seg_cs;
      SEG_DATA:  seg_v = seg_ds;
      SEG_STACK: seg_v = seg_ss;
      default:   seg_v = seg_es;
    endcase
  end

  assign pa_d = {seg_v, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea_d};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q  <= '0;
      seg_q <= SEG_CODE;
      pa_q  <= '0;
    end else begin
      ea_q  <= ea_d;
      seg_q <= seg_d;
      pa_q  <= pa_d;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int EA_W      = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = EA_W + SEG_SHIFT
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      base_sel,
  input logic            ovr_en,
  input logic [1:0]      ovr_seg,
  input logic            str_dst,
  input logic [EA_W-1:0] seg_cs,
  input logic [EA_W-1:0] seg_ds,
  input logic [EA_W-1:0] seg_ss,
  input logic [EA_W-1:0] seg_es,
  input logic [EA_W-1:0] ea_q,
  input logic [1:0]      seg_q,
  input logic [PA_W-1:0] pa_q
);
  logic            p_rst_n, p_str, p_ovr, p_bp;
  logic [1:0]      p_oseg;
  logic [EA_W-1:0] p_cs, p_ds, p_ss, p_es, p_sv;

  always_ff @(posedge clk) begin
    p_rst_n <= rst_n;
    p_str   <= str_dst;
    p_ovr   <= ovr_en;
    p_oseg  <= ovr_seg;
    p_bp    <= (base_sel == 2'd2);
    p_cs    <= seg_cs;
    p_ds    <= seg_ds;
    p_ss    <= seg_ss;
    p_es    <= seg_es;
  end

  always_comb
    case (seg_q)
      2'd0:    p_sv = p_cs;
      2'd1:    p_sv = p_ds;
      2'd2:    p_sv = p_ss;
      default: p_sv = p_es;
    endcase

  assert_pa_compose_R7: assert property (@(posedge clk) disable iff (!rst_n)
    p_rst_n |-> pa_q == ({p_sv, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea_q}));
  assert_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rst_n && p_ovr && !p_str) |-> seg_q == p_oseg);
  assert_string_extra_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rst_n && p_str) |-> seg_q == 2'd3);
  assert_bp_stack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rst_n && !p_str && !p_ovr && p_bp) |-> seg_q == 2'd2);
  assert_no_extra_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rst_n && !p_str && !p_ovr) |-> seg_q != 2'd3);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.EA_W(EA_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .ovr_en(ovr_en),
  .ovr_seg(ovr_seg), .str_dst(str_dst), .seg_cs(seg_cs), .seg_ds(seg_ds),
  .seg_ss(seg_ss), .seg_es(seg_es), .ea_q(ea_q), .seg_q(seg_q), .pa_q(pa_q));

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  base_sel = 0, idx_sel = 0, disp_mode = 0, ovr_seg = 0;
  logic [15:0] disp = 0, reg_bx = 0, reg_bp = 0, reg_si = 0, reg_di = 0;
  logic [15:0] seg_cs = 0, seg_ds = 0, seg_ss = 0, seg_es = 0;
  logic        ovr_en = 0, str_dst = 0;
  logic [15:0] ea_q;
  logic [1:0]  seg_q;
  logic [19:0] pa_q;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  seg_addr_gen u0 (.*);

  task automatic cmp(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] b, input logic [1:0] i, input logic [1:0] dm,
                       input logic [15:0] d, input logic oe, input logic [1:0] os,
                       input logic sd, input logic [15:0] exp_ea,
                       input logic [1:0] exp_seg, input logic [19:0] exp_pa);
    logic [15:0] old_ea;
    @(negedge clk);
    old_ea = ea_q;
    base_sel = b; idx_sel = i; disp_mode = dm; disp = d;
    ovr_en = oe; ovr_seg = os; str_dst = sd;
    #1 cmp("R8 hold before edge", {4'h0, ea_q}, {4'h0, old_ea});
    @(negedge clk);
    cmp("R1 ea", {4'h0, ea_q}, {4'h0, exp_ea});
    cmp("R4/R5/R6 seg", {18'h0, seg_q}, {18'h0, exp_seg});
    cmp("R7 pa", pa_q, exp_pa);
  endtask

  task automatic t_reset;
    @(negedge clk);
    cmp("R9 reset ea", {4'h0, ea_q}, 20'h0);
    cmp("R9 reset seg", {18'h0, seg_q}, 20'h0);
    cmp("R9 reset pa", pa_q, 20'h0);
  endtask

  task automatic t_bx_disp16;  // R2 mode 2, R4 data
    seg_ds = 16'h2314; reg_bx = 16'h3255;
    apply(2'd1, 2'd0, 2'd2, 16'h0020, 0, 0, 0, 16'h3275, 2'd1, 20'h263B5);
  endtask

  task automatic t_bp_disp8_neg;  // R2 sign-extend, R4 stack
    seg_ss = 16'h9000; reg_bp = 16'hFFF2;
    apply(2'd2, 2'd0, 2'd1, 16'h12FC, 0, 0, 0, 16'hFFEE, 2'd2, 20'h9FFEE);
  endtask

  task automatic t_ea_wrap;  // R1 wrap, R3 SI
    reg_bx = 16'hFFFF; reg_si = 16'h0002;
    apply(2'd1, 2'd1, 2'd0, 16'h7777, 0, 0, 0, 16'h0001, 2'd1, 20'h23141);
  endtask

  task automatic t_disp8_pos_di;  // R2 positive byte, R3 DI only
    reg_di = 16'h1000;
    apply(2'd0, 2'd2, 2'd1, 16'hAB7F, 0, 0, 0, 16'h107F, 2'd1, 20'h241BF);
  endtask

  task automatic t_unused_sel;  // R3 code 3 ignored, R2 code 3 ignored
    apply(2'd3, 2'd3, 2'd3, 16'h4444, 0, 0, 0, 16'h0000, 2'd1, 20'h23140);
  endtask

  task automatic t_bp_di;  // R4 BP+DI uses stack, R10
    reg_bp = 16'h0100; reg_di = 16'h0010;
    apply(2'd2, 2'd2, 2'd0, 16'h0, 0, 0, 0, 16'h0110, 2'd2, 20'h90110);
  endtask

  task automatic t_pa_wrap;  // R7 wrap past 1 MB
    seg_ds = 16'hFFFF; reg_bx = 16'h0020;
    apply(2'd1, 2'd0, 2'd0, 16'h0, 0, 0, 0, 16'h0020, 2'd1, 20'h00010);
  endtask

  task automatic t_override;  // R5 override to code segment
    seg_cs = 16'h1000; reg_bp = 16'h0004;
    apply(2'd2, 2'd0, 2'd0, 16'h0, 1, 2'd0, 0, 16'h0004, 2'd0, 20'h10004);
  endtask

  task automatic t_string;  // R6 extra wins over override
    seg_es = 16'h0ABC; reg_di = 16'h0008;
    apply(2'd0, 2'd2, 2'd0, 16'h0, 1, 2'd2, 1, 16'h0008, 2'd3, 20'h0ABC8);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    seg_ds = 16'h2314;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1;
    t_bx_disp16();
    t_bp_disp8_neg();
    t_ea_wrap();
    t_disp8_pos_di();
    t_unused_sel();
    t_bp_di();
    t_pa_wrap();
    t_override();
    t_string();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule